// File: doc/BRIEF.md
# Five-Function Arithmetic-Logic Unit with Zero Flag

This block is a purely combinational 32-bit arithmetic-logic unit. It takes two operands and a 3-bit control word. It returns a result word, a zero flag and the carry out of the top adder bit. The functions are bitwise AND, bitwise OR, addition, subtraction and signed set-less-than. The control word is split into a subtract bit and a 2-bit result selector. The subtract bit inverts operand B and also supplies the adder carry-in, so one adder forms both the sum and the difference.

A processor datapath uses the block in three ways. Arithmetic and logic instructions use it directly. Loads and stores use the add code to form effective addresses. Branch-on-equal issues the subtract code and reads the zero flag. The block has no clock and no state, so every output follows its inputs within the same cycle.

Top module: `alu5_core`

## Requirements
- R1: Control code 3'b000 gives result = A & B, bit by bit.
- R2: Control code 3'b001 gives result = A | B, bit by bit.
- R3: Control code 3'b010 gives result = (A + B) mod 2^32, and carry_out is the carry out of bit 31 of that sum.
- R4: Control code 3'b110 gives result = (A - B) mod 2^32, computed as A + ~B + 1. carry_out is 1 exactly when A >= B as unsigned numbers.
- R5: Control code 3'b111 gives result = 1 when A < B as signed two's-complement numbers and 0 otherwise. Bits 31..1 are always zero. The answer stays correct when A - B overflows.
- R6: zero_flag is 1 exactly when all 32 result bits are 0, for every control code.
- R7: Control codes 3'b011, 3'b100 and 3'b101 drive the result to all zeros, so zero_flag reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (inverted internally when subtracting) |
| ctrl | input | 3 | {subtract bit, result selector[1:0]} |
| result | output | 32 | Function result |
| zero_flag | output | 1 | High when result is all zeros |
| carry_out | output | 1 | Adder carry out of bit 31; meaningful for codes 3'b010 and 3'b110 |

## Verification
Every output of this block is due in the same cycle as its stimulus, with zero register stages, so results are due zero cycles after the inputs change. The bench changes operands and control on the falling clock edge. It compares result, zero flag and carry against its behavioural model on the next rising edge, half a period later, when the logic has settled. The carry is compared only for the add and subtract codes. Corner operands are included so that signed overflow in the less-than path, equal operands and wrap-around are all exercised: zero, one, all ones, the most negative value and the most positive value.

// File: rtl/alu5_pkg.sv
package alu5_pkg;
  localparam int CTRL_W = 3;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sel_e;

  // Legal control words: {sub, sel}
  localparam logic [CTRL_W-1:0] CODE_AND = 3'b000;
  localparam logic [CTRL_W-1:0] CODE_OR  = 3'b001;
  localparam logic [CTRL_W-1:0] CODE_ADD = 3'b010;
  localparam logic [CTRL_W-1:0] CODE_SUB = 3'b110;
  localparam logic [CTRL_W-1:0] CODE_SLT = 3'b111;

  function automatic logic code_is_legal(input logic [CTRL_W-1:0] c);
    return (c == CODE_AND) || (c == CODE_OR) || (c == CODE_ADD) ||
           (c == CODE_SUB) || (c == CODE_SLT);
  endfunction
endpackage

// File: rtl/alu5_bitwise.sv
module alu5_bitwise #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] and_v,
  output logic [W-1:0] or_v
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_v[i] = x[i] & y[i];
    assign or_v[i]  = x[i] | y[i];
  end

  always_comb begin
    // R1/R2: AND never exceeds OR in any bit position
    a_r1_and_within_or: assert ((and_v & ~or_v) == '0)
      else $error("and/or relation broken");
  end
endmodule

// File: rtl/alu5_addsub.sv
module alu5_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  function automatic logic [W:0] add_ext(input logic [W-1:0] p,
                                         input logic [W-1:0] q,
                                         input logic         cin);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, cin};
  endfunction

  function automatic logic signed_ovf(input logic pm, input logic qm,
                                      input logic sm);
    return (pm == qm) && (sm != pm);
  endfunction

  logic [W-1:0] y_eff;
  logic [W:0]   wide;

  assign y_eff = y ^ {W{sub}};
  assign wide  = add_ext(x, y_eff, sub);
  assign sum   = wide[W-1:0];
  assign carry = wide[W];
  assign ovf   = signed_ovf(x[W-1], y_eff[W-1], sum[W-1]);

  always_comb begin
    // R4: carry out of a subtraction means no unsigned borrow
    if (sub)
      a_r4_no_borrow: assert (carry == (x >= y))
        else $error("subtract carry disagrees with unsigned compare");
    // R3: carry out of an addition means the sum wrapped
    if (!sub)
      a_r3_wrap_carry: assert (carry == (sum < x))
        else $error("add carry disagrees with wrap");
  end
endmodule

// File: rtl/alu5_lessthan.sv
module alu5_lessthan (
  input  logic diff_msb,
  input  logic ovf,
  output logic lt
);
  // Sign of the difference, corrected when the subtraction overflowed
  assign lt = diff_msb ^ ovf;
endmodule

// File: rtl/alu5_core.sv
module alu5_core
  import alu5_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [W-1:0]      result,
  output logic              zero_flag,
  output logic              carry_out
);
  logic         sub_bit;
  sel_e         sel;
  logic         legal;
  logic [W-1:0] and_v, or_v, sum_v;
  logic         add_carry, add_ovf, less_bit;

  assign sub_bit = ctrl[CTRL_W-1];
  assign sel     = sel_e'(ctrl[1:0]);
  assign legal   = code_is_legal(ctrl);

  alu5_bitwise #(.W(W)) u_bitwise (
    .x(opnd_a), .y(opnd_b), .and_v(and_v), .or_v(or_v)
  );

  alu5_addsub #(.W(W)) u_addsub (
    .x(opnd_a), .y(opnd_b), .sub(sub_bit),
    .sum(sum_v), .carry(add_carry), .ovf(add_ovf)
  );

  alu5_lessthan u_less (
    .diff_msb(sum_v[W-1]), .ovf(add_ovf), .lt(less_bit)
  );

  always_comb begin
    result = '0;
    if (legal) begin
      unique case (sel)
        SEL_AND:  result = and_v;
        SEL_OR:   result = or_v;
        SEL_SUM:  result = sum_v;
        SEL_LESS: result = {{(W-1){1'b0}}, less_bit};
        default:  result = '0;
      endcase
    end
  end

  assign zero_flag = ~|result;
  assign carry_out = add_carry;

  always_comb begin
    // R5: signed less-than agrees with a direct signed compare
    if (ctrl == CODE_SLT)
      a_r5_signed_lt: assert (result[0] == ($signed(opnd_a) < $signed(opnd_b)))
        else $error("set-less-than wrong");
    // R5: upper bits of the less-than result are clear
    if (ctrl == CODE_SLT)
      a_r5_upper_clear: assert ($countones(result[W-1:1]) == 0)
        else $error("set-less-than upper bits set");
    // R4: equal operands subtract to zero and raise the flag
    if (ctrl == CODE_SUB && opnd_a == opnd_b)
      a_r4_equal_zero: assert (zero_flag)
        else $error("equal operands did not give zero");
    // R6: a raised flag implies no set result bit
    if (zero_flag)
      a_r6_flag_clean: assert ($countones(result) == 0)
        else $error("zero flag with nonzero result");
    // R7: unused codes produce zero
    if (!legal)
      a_r7_unused_zero: assert (result == '0 && zero_flag)
        else $error("unused code produced data");
  end
endmodule

// File: tb/alu5_core_tb.sv
module alu5_core_tb;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [2:0]  c;
  logic [31:0] result;
  logic        zero_flag, carry_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #2 clk = ~clk;  // 250 MHz

  alu5_core u_dut (
    .opnd_a(a), .opnd_b(b), .ctrl(c),
    .result(result), .zero_flag(zero_flag), .carry_out(carry_out)
  );

  function automatic string tag_of(input logic [2:0] code);
    case (code)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b110:  return "R4";
      3'b111:  return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [31:0] va, input logic [31:0] vb,
                       input logic [2:0] vc);
    longint unsigned ua, ub, s;
    logic [31:0] er;
    logic        ec;
    logic        chk_c;
    @(negedge clk);
    a = va; b = vb; c = vc;
    ua = longint'(va); ub = longint'(vb);
    er = 32'd0; ec = 1'b0; chk_c = 1'b0;
    case (vc)
      3'b000: er = va & vb;
      3'b001: er = va | vb;
      3'b010: begin s = ua + ub; er = s[31:0]; ec = s[32]; chk_c = 1'b1; end
      3'b110: begin er = va - vb; ec = (ua >= ub); chk_c = 1'b1; end
      3'b111: er = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
      default: er = 32'd0;
    endcase
    @(posedge clk);
    vectors++;
    if (result !== er) begin
      errors++;
      $display("FAIL %s result a=%h b=%h ctrl=%b: got %h exp %h",
               tag_of(vc), va, vb, vc, result, er);
    end
    vectors++;
    if (zero_flag !== (er == 32'd0)) begin
      errors++;
      $display("FAIL R6 zero_flag a=%h b=%h ctrl=%b: got %b exp %b",
               va, vb, vc, zero_flag, (er == 32'd0));
    end
    if (chk_c) begin
      vectors++;
      if (carry_out !== ec) begin
        errors++;
        $display("FAIL %s carry a=%h b=%h ctrl=%b: got %b exp %b",
                 tag_of(vc), va, vb, vc, carry_out, ec);
      end
    end
  endtask

  logic [31:0] corners [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF,
                               32'h8000_0000, 32'h7FFF_FFFF};

  initial begin
    a = '0; b = '0; c = '0;
    // Idle state: zero operands with AND give zero and raise the flag (R1, R6)
    apply(32'h0, 32'h0, 3'b000);
    // Signed overflow in the compare: most negative < most positive (R5)
    apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b111);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 3'b111);
    // Equal operands for branch-style compare (R4, R6)
    apply(32'h1234_5678, 32'h1234_5678, 3'b110);
    // Unused codes with busy operands (R7)
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b100);
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b101);
    // Corner sweep over every code (R1..R7)
    for (int code = 0; code < 8; code++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply(corners[i], corners[j], 3'(code));
    // Random sweep over every code
    for (int n = 0; n < 300; n++)
      for (int code = 0; code < 8; code++)
        apply($urandom, $urandom, 3'(code));
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired: got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule